// File: doc/BRIEF.md
# UART Channel Buffering and Flow-Control Core

This block is the data-path core of one asynchronous serial channel. On the bus side, a register interface pushes bytes into a transmit queue and pops received bytes from a receive queue. On the line side, it hands bytes to a transmit shifter through a load handshake and accepts bytes from a receive shifter through a valid strobe. It also carries that byte's parity, framing and break indications. The serial bit timing is outside this block.

Each queue holds `DEPTH` bytes when queue mode is on. With queue mode off, each queue shrinks to a single holding slot. Automatic flow control drives the active-low request-to-send output from the free space in the receive queue, with hysteresis. It also stalls the transmit queue while the active-low clear-to-send input is high. With automatic flow control off, request-to-send follows a software bit and clear-to-send is ignored.

Receive and transmit requests are level signals that compare queue occupancy with programmable trigger levels. Each one is steered to an interrupt line, to a DMA request line, or to neither. Four sticky receive error flags feed a separately enabled error interrupt.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: While `rst` is high, both counts read 0, `rts_n` reads 1, and all request outputs and all four error flags read 0.
- R2: Each queue returns bytes in arrival order. Its count is capped at `DEPTH` in queue mode and at 1 in holding mode. A push to a queue at its cap leaves the count unchanged.
- R3: With `cfg_afc_en=1` and queue mode on, `rts_n` goes to 0 when receive free space (`DEPTH` minus count) is above 2. It goes to 1 when free space is 0, and it keeps its value otherwise. It changes on the same clock edge as the count.
- R4: `txs_load` is high exactly when `txs_idle` is high, the transmit queue is not empty, and, with `cfg_afc_en=1`, `cts_n` is 0. With `cfg_afc_en=0`, `cts_n` has no effect. `txs_data` is the oldest queued byte.
- R5: With `cfg_afc_en=0`, `rts_n` equals the inverse of `cfg_rts_sw` from the next clock edge.
- R6: In queue mode, the receive condition is (receive count >= `cfg_rx_trig`).
- R7: In queue mode, the transmit condition is (transmit count <= `cfg_tx_trig`), so it is already true while the queue is empty.
- R8: In holding mode, the receive condition is "holding slot full" and the transmit condition is "holding slot empty". With `cfg_afc_en=1`, `rts_n` is 0 while the receive slot is empty and 1 while it is full.
- R9: Mode code 1 routes a condition to the `irq_*` output and code 2 routes it to the `dma_*` output. Codes 0 and 3 drive both outputs low. All request outputs are registered from the post-edge counts, so they change on the same clock edge as the counts.
- R10: A receive byte that arrives while the receive queue is at its cap is dropped, and the overrun flag is set.
- R11: The error flags are bit 0 overrun, bit 1 parity, bit 2 frame and bit 3 break. A flag sets when `rxs_valid` carries the matching indication. `irq_err` is high only while `cfg_err_ie=1` and some flag is set.
- R12: A pulse on `err_rd` clears all flags. A flag that is set in the same cycle as the pulse is kept.
- R13: `st_rx_ready` shows that the receive queue is not empty. `st_tx_empty` shows that the transmit queue is empty. `st_tx_shift_empty` shows that the transmit queue is empty and `txs_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1 = queue mode, 0 = single holding slot |
| cfg_afc_en | input | 1 | Automatic flow control enable |
| cfg_rts_sw | input | 1 | Software request-to-send (1 = assert) |
| cfg_rx_mode | input | 2 | Receive request routing: 0 off, 1 interrupt, 2 DMA, 3 off |
| cfg_tx_mode | input | 2 | Transmit request routing, same codes |
| cfg_err_ie | input | 1 | Error interrupt enable |
| cfg_rx_trig | input | CW | Receive trigger level |
| cfg_tx_trig | input | CW | Transmit trigger level |
| tx_wr_en | input | 1 | Push `tx_wr_data` into the transmit queue |
| tx_wr_data | input | DW | Byte to transmit |
| rx_rd_en | input | 1 | Pop the oldest received byte |
| rx_rd_data | output | DW | Oldest received byte |
| err_rd | input | 1 | Error status read strobe (clears flags) |
| err_flags | output | 4 | Sticky error flags |
| txs_idle | input | 1 | Transmit shifter can take a byte |
| txs_load | output | 1 | Byte handed to the transmit shifter this cycle |
| txs_data | output | DW | Byte for the transmit shifter |
| rxs_valid | input | 1 | Receive shifter delivers a byte |
| rxs_data | input | DW | Delivered byte |
| rxs_perr | input | 1 | Parity error on the delivered byte |
| rxs_ferr | input | 1 | Framing error on the delivered byte |
| rxs_brk | input | 1 | Break detected |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| tx_count | output | CW | Transmit queue occupancy |
| rx_count | output | CW | Receive queue occupancy |
| st_rx_ready | output | 1 | Receive data available |
| st_tx_empty | output | 1 | Transmit queue empty |
| st_tx_shift_empty | output | 1 | Transmit queue empty and shifter idle |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Error interrupt request |
| dma_rx | output | 1 | Receive DMA request |
| dma_tx | output | 1 | Transmit DMA request |

## Verification
The properties assume that the configuration inputs stay steady while traffic flows. The flow-control property relaxes only on the cycle after `cfg_afc_en` or `cfg_fifo_en` changes. They also assume that `DEPTH` is a power of two, so the queue pointers wrap by plain overflow. The stimulus changes configuration only on idle cycles between phases. It never pops and pushes the receive queue in the same cycle at its cap, so the overrun cases are unambiguous. Every input is driven on the falling clock edge.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  typedef enum logic [1:0] {
    REQ_OFF  = 2'd0,
    REQ_IRQ  = 2'd1,
    REQ_DMA  = 2'd2,
    REQ_RSVD = 2'd3
  } req_mode_e;

  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;
  localparam int ERR_W   = 4;
endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  // holding mode uses slot capacity 1 on the same storage
  assign cap     = fifo_en ? DEPTH_C : CW'(1);
  assign do_push = push && (count < cap);
  assign do_pop  = pop && (count != '0);
  assign empty   = (count == '0);
  assign head    = mem[rptr];

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop)      count_nxt = count + CW'(1);
    else if (do_pop && !do_push) count_nxt = count - CW'(1);
  end

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/ufc_rts.sv
module ufc_rts #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          afc_en,
  input  logic          fifo_en,
  input  logic          sw_rts,
  input  logic [CW-1:0] cnt_nxt,
  output logic          rts_n
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] free_nxt;
  logic          rts_n_nxt;

  assign free_nxt = DEPTH_C - cnt_nxt;

  always_comb begin
    rts_n_nxt = rts_n;
    if (!afc_en) begin
      rts_n_nxt = !sw_rts;
    end else if (!fifo_en) begin
      rts_n_nxt = (cnt_nxt != '0);
    end else if (free_nxt > CW'(2)) begin
      rts_n_nxt = 1'b0;
    end else if (free_nxt == '0) begin
      rts_n_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b1;
    else     rts_n <= rts_n_nxt;
  end
endmodule

// File: rtl/ufc_req.sv
module ufc_req
  import ufc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cond_nxt,
  output logic       irq,
  output logic       dma
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      dma <= 1'b0;
    end else begin
      irq <= cond_nxt && (mode == REQ_IRQ);
      dma <= cond_nxt && (mode == REQ_DMA);
    end
  end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import ufc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_fifo_en,
  input  logic          cfg_afc_en,
  input  logic          cfg_rts_sw,
  input  logic [1:0]    cfg_rx_mode,
  input  logic [1:0]    cfg_tx_mode,
  input  logic          cfg_err_ie,
  input  logic [CW-1:0] cfg_rx_trig,
  input  logic [CW-1:0] cfg_tx_trig,
  input  logic          tx_wr_en,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          rx_rd_en,
  output logic [DW-1:0] rx_rd_data,
  input  logic          err_rd,
  output logic [3:0]    err_flags,
  input  logic          txs_idle,
  output logic          txs_load,
  output logic [DW-1:0] txs_data,
  input  logic          rxs_valid,
  input  logic [DW-1:0] rxs_data,
  input  logic          rxs_perr,
  input  logic          rxs_ferr,
  input  logic          rxs_brk,
  input  logic          cts_n,
  output logic          rts_n,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          st_rx_ready,
  output logic          st_tx_empty,
  output logic          st_tx_shift_empty,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_err,
  output logic          dma_rx,
  output logic          dma_tx
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0]    tx_cnt_nxt, rx_cnt_nxt, rx_cap;
  logic             tx_empty, rx_empty, rx_drop;
  logic             tx_cond_nxt, rx_cond_nxt;
  logic [ERR_W-1:0] err_new, err_nxt;

  // transmit path
  assign txs_load = txs_idle && !tx_empty && (!cfg_afc_en || !cts_n);

  ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (cfg_fifo_en),
    .push      (tx_wr_en),
    .push_data (tx_wr_data),
    .pop       (txs_load),
    .head      (txs_data),
    .empty     (tx_empty),
    .count     (tx_count),
    .count_nxt (tx_cnt_nxt)
  );

  // receive path
  ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (cfg_fifo_en),
    .push      (rxs_valid),
    .push_data (rxs_data),
    .pop       (rx_rd_en),
    .head      (rx_rd_data),
    .empty     (rx_empty),
    .count     (rx_count),
    .count_nxt (rx_cnt_nxt)
  );

  assign rx_cap  = cfg_fifo_en ? DEPTH_C : CW'(1);
  assign rx_drop = rxs_valid && (rx_count >= rx_cap);

  ufc_rts #(.DEPTH(DEPTH)) u_rts (
    .clk     (clk),
    .rst     (rst),
    .afc_en  (cfg_afc_en),
    .fifo_en (cfg_fifo_en),
    .sw_rts  (cfg_rts_sw),
    .cnt_nxt (rx_cnt_nxt),
    .rts_n   (rts_n)
  );

  // request conditions from post-edge occupancy
  assign rx_cond_nxt = cfg_fifo_en ? (rx_cnt_nxt >= cfg_rx_trig) : (rx_cnt_nxt != '0);
  assign tx_cond_nxt = cfg_fifo_en ? (tx_cnt_nxt <= cfg_tx_trig) : (tx_cnt_nxt == '0);

  ufc_req u_rx_req (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_rx_mode),
    .cond_nxt (rx_cond_nxt),
    .irq      (irq_rx),
    .dma      (dma_rx)
  );

  ufc_req u_tx_req (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_tx_mode),
    .cond_nxt (tx_cond_nxt),
    .irq      (irq_tx),
    .dma      (dma_tx)
  );

  // sticky receive error status
  always_comb begin
    err_new          = '0;
    err_new[ERR_OVR] = rx_drop;
    err_new[ERR_PAR] = rxs_valid && rxs_perr;
    err_new[ERR_FRM] = rxs_valid && rxs_ferr;
    err_new[ERR_BRK] = rxs_valid && rxs_brk;
    err_nxt          = (err_rd ? '0 : err_flags) | err_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      irq_err   <= 1'b0;
    end else begin
      err_flags <= err_nxt;
      irq_err   <= cfg_err_ie && (err_nxt != '0);
    end
  end

  assign st_rx_ready       = !rx_empty;
  assign st_tx_empty       = tx_empty;
  assign st_tx_shift_empty = tx_empty && txs_idle;
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_fifo_en,
  input logic          cfg_afc_en,
  input logic          cfg_err_ie,
  input logic          cts_n,
  input logic          txs_load,
  input logic          rxs_valid,
  input logic          rts_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [3:0]    err_flags,
  input logic          irq_rx,
  input logic          dma_rx,
  input logic          irq_tx,
  input logic          dma_tx,
  input logic          irq_err
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (rx_count <= DEPTH_C) && (tx_count <= DEPTH_C));

  a_r3_rts_off_when_full: assert property (@(posedge clk) disable iff (rst)
    (cfg_afc_en && cfg_fifo_en && $stable(cfg_afc_en) && $stable(cfg_fifo_en)
     && rx_count == DEPTH_C) |-> rts_n);

  a_r4_cts_blocks_load: assert property (@(posedge clk) disable iff (rst)
    (cfg_afc_en && cts_n) |-> !txs_load);

  a_r9_route_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(irq_rx && dma_rx) && !(irq_tx && dma_tx));

  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (rxs_valid && rx_count == (cfg_fifo_en ? DEPTH_C : CW'(1))) |=> err_flags[0]);

  a_r11_err_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !cfg_err_ie |=> !irq_err);
endmodule

bind uart_fifo_ctrl ufc_checker #(.DEPTH(DEPTH)) u_ufc_checker (
  .clk         (clk),
  .rst         (rst),
  .cfg_fifo_en (cfg_fifo_en),
  .cfg_afc_en  (cfg_afc_en),
  .cfg_err_ie  (cfg_err_ie),
  .cts_n       (cts_n),
  .txs_load    (txs_load),
  .rxs_valid   (rxs_valid),
  .rts_n       (rts_n),
  .rx_count    (rx_count),
  .tx_count    (tx_count),
  .err_flags   (err_flags),
  .irq_rx      (irq_rx),
  .dma_rx      (dma_rx),
  .irq_tx      (irq_tx),
  .dma_tx      (dma_tx),
  .irq_err     (irq_err)
);

// File: tb/uart_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_fifo_en, cfg_afc_en, cfg_rts_sw, cfg_err_ie;
  logic [1:0]    cfg_rx_mode, cfg_tx_mode;
  logic [CW-1:0] cfg_rx_trig, cfg_tx_trig;
  logic          tx_wr_en, rx_rd_en, err_rd, txs_idle, rxs_valid;
  logic          rxs_perr, rxs_ferr, rxs_brk, cts_n;
  logic [DW-1:0] tx_wr_data, rxs_data, rx_rd_data, txs_data;
  logic [3:0]    err_flags;
  logic          txs_load, rts_n, st_rx_ready, st_tx_empty, st_tx_shift_empty;
  logic [CW-1:0] tx_count, rx_count;
  logic          irq_rx, irq_tx, irq_err, dma_rx, dma_tx;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_uart_fifo_ctrl (.*);

  typedef struct packed {
    logic       pop;
    logic [7:0] cnt;
    logic       rts;
    logic       irq;
  } vec_t;

  // receive fill then partial drain, trigger 4, automatic flow control on
  localparam vec_t VECS [20] = '{
    '{1'b0, 8'd1,  1'b0, 1'b0}, '{1'b0, 8'd2,  1'b0, 1'b0},
    '{1'b0, 8'd3,  1'b0, 1'b0}, '{1'b0, 8'd4,  1'b0, 1'b1},
    '{1'b0, 8'd5,  1'b0, 1'b1}, '{1'b0, 8'd6,  1'b0, 1'b1},
    '{1'b0, 8'd7,  1'b0, 1'b1}, '{1'b0, 8'd8,  1'b0, 1'b1},
    '{1'b0, 8'd9,  1'b0, 1'b1}, '{1'b0, 8'd10, 1'b0, 1'b1},
    '{1'b0, 8'd11, 1'b0, 1'b1}, '{1'b0, 8'd12, 1'b0, 1'b1},
    '{1'b0, 8'd13, 1'b0, 1'b1}, '{1'b0, 8'd14, 1'b0, 1'b1},
    '{1'b0, 8'd15, 1'b0, 1'b1}, '{1'b0, 8'd16, 1'b1, 1'b1},
    '{1'b1, 8'd15, 1'b1, 1'b1}, '{1'b1, 8'd14, 1'b1, 1'b1},
    '{1'b1, 8'd13, 1'b0, 1'b1}, '{1'b1, 8'd12, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] d);
    rxs_valid = 1'b1; rxs_data = d;
    tick();
    rxs_valid = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_wr_en = 1'b1; tx_wr_data = d;
    tick();
    tx_wr_en = 1'b0;
  endtask

  task automatic rx_pop();
    rx_rd_en = 1'b1;
    tick();
    rx_rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cfg_fifo_en = 1'b0; cfg_afc_en = 1'b0; cfg_rts_sw = 1'b0; cfg_err_ie = 1'b0;
    cfg_rx_mode = 2'd0; cfg_tx_mode = 2'd0; cfg_rx_trig = '0; cfg_tx_trig = '0;
    tx_wr_en = 1'b0; rx_rd_en = 1'b0; err_rd = 1'b0; txs_idle = 1'b0;
    rxs_valid = 1'b0; rxs_perr = 1'b0; rxs_ferr = 1'b0; rxs_brk = 1'b0; cts_n = 1'b1;
    tx_wr_data = '0; rxs_data = '0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rts_n", rts_n, 1);
    chk("R1 requests", {irq_rx, irq_tx, irq_err, dma_rx, dma_tx}, 0);
    chk("R1 err_flags", err_flags, 0);
    rst = 1'b0;

    // table walk: R2 R3 R6
    cfg_fifo_en = 1'b1; cfg_afc_en = 1'b1; cfg_rx_mode = 2'd1; cfg_rx_trig = CW'(4);
    tick();
    chk("R3 rts_n active when empty", rts_n, 0);
    begin
      int pop_idx = 0;
      for (int i = 0; i < 20; i++) begin
        if (VECS[i].pop) begin
          chk("R2 pop order", rx_rd_data, pop_idx);
          pop_idx++;
          rx_pop();
        end else begin
          rx_push(8'(i));
        end
        chk("R2 rx_count", rx_count, VECS[i].cnt);
        chk("R3 rts_n hysteresis", rts_n, VECS[i].rts);
        chk("R6 irq_rx level", irq_rx, VECS[i].irq);
      end
    end

    // R10 overrun at full
    for (int i = 0; i < 4; i++) rx_push(8'(16 + i));
    chk("R2 full count", rx_count, 16);
    rx_push(8'h99);
    chk("R10 count after drop", rx_count, 16);
    chk("R10 overrun flag", err_flags, 4'b0001);
    chk("R11 irq_err masked", irq_err, 0);
    cfg_err_ie = 1'b1;
    tick();
    chk("R11 irq_err enabled", irq_err, 1);
    err_rd = 1'b1; tick(); err_rd = 1'b0;
    chk("R12 read clears", err_flags, 0);
    chk("R11 irq_err drops", irq_err, 0);
    chk("R2 oldest after drain", rx_rd_data, 4);
    for (int i = 0; i < 15; i++) rx_pop();
    chk("R2 last byte kept, dropped byte absent", rx_rd_data, 19);
    rx_pop();
    chk("R13 rx not ready", st_rx_ready, 0);

    // R12 same-cycle set survives read, R11 bit positions
    rxs_perr = 1'b1; rxs_brk = 1'b1; err_rd = 1'b1;
    rx_push(8'h55);
    rxs_perr = 1'b0; rxs_brk = 1'b0; err_rd = 1'b0;
    chk("R12 set kept over read", err_flags, 4'b1010);
    chk("R13 rx ready", st_rx_ready, 1);
    rxs_ferr = 1'b1; rx_push(8'h56); rxs_ferr = 1'b0;
    chk("R11 frame bit", err_flags, 4'b1110);
    err_rd = 1'b1; tick(); err_rd = 1'b0;
    rx_pop(); rx_pop();

    // R9 routing
    cfg_rx_mode = 2'd2;
    for (int i = 0; i < 4; i++) rx_push(8'(i));
    chk("R9 dma_rx", dma_rx, 1);
    chk("R9 irq_rx off in dma", irq_rx, 0);
    cfg_rx_mode = 2'd0; tick();
    chk("R9 mode0 off", {irq_rx, dma_rx}, 0);
    cfg_rx_mode = 2'd3; tick();
    chk("R9 mode3 off", {irq_rx, dma_rx}, 0);
    for (int i = 0; i < 4; i++) rx_pop();

    // R7 transmit level
    cfg_tx_mode = 2'd1; cfg_tx_trig = CW'(2); cfg_afc_en = 1'b0; txs_idle = 1'b0;
    tick();
    chk("R7 irq_tx while empty", irq_tx, 1);
    chk("R13 tx empty", st_tx_empty, 1);
    chk("R13 shift busy", st_tx_shift_empty, 0);
    tx_push(8'hA0); tx_push(8'hA1); tx_push(8'hA2);
    chk("R2 tx_count", tx_count, 3);
    chk("R7 irq_tx above trigger", irq_tx, 0);

    // R4 clear-to-send gating
    cfg_afc_en = 1'b1; cts_n = 1'b1; txs_idle = 1'b1;
    #1;
    chk("R4 load blocked", txs_load, 0);
    tick();
    chk("R4 count held", tx_count, 3);
    cts_n = 1'b0;
    #1;
    chk("R4 load allowed", txs_load, 1);
    chk("R4 head byte", txs_data, 8'hA0);
    tick();
    txs_idle = 1'b0;
    chk("R4 count after load", tx_count, 2);
    chk("R7 irq_tx at trigger", irq_tx, 1);
    cfg_afc_en = 1'b0; cts_n = 1'b1; txs_idle = 1'b1;
    #1;
    chk("R4 cts ignored without afc", txs_load, 1);
    chk("R4 second byte", txs_data, 8'hA1);
    tick(); tick();
    chk("R4 drained", tx_count, 0);
    chk("R13 shifter empty", st_tx_shift_empty, 1);

    // R5 software request-to-send
    cfg_rts_sw = 1'b1; tick();
    chk("R5 rts_n follows sw", rts_n, 0);
    cfg_rts_sw = 1'b0; tick();
    chk("R5 rts_n released", rts_n, 1);

    // R8 holding mode
    cfg_fifo_en = 1'b0; cfg_afc_en = 1'b1; cfg_rx_mode = 2'd1; cfg_rx_trig = CW'(8);
    txs_idle = 1'b0; tick();
    chk("R8 rts_n slot empty", rts_n, 0);
    chk("R8 irq_tx slot empty", irq_tx, 1);
    rx_push(8'h3C);
    chk("R8 irq_rx slot full", irq_rx, 1);
    chk("R8 rts_n slot full", rts_n, 1);
    rx_push(8'h3D);
    chk("R2 holding cap", rx_count, 1);
    chk("R10 overrun in holding", err_flags[0], 1);
    chk("R2 holding data", rx_rd_data, 8'h3C);
    rx_pop();
    tx_push(8'hB0);
    chk("R8 irq_tx slot full", irq_tx, 0);
    tx_push(8'hB1);
    chk("R2 tx holding cap", tx_count, 1);
    cfg_tx_mode = 2'd2; cfg_afc_en = 1'b0; txs_idle = 1'b1;
    tick();
    chk("R8 holding emptied", tx_count, 0);
    chk("R9 dma_tx", dma_tx, 1);
    chk("R9 irq_tx off in dma", irq_tx, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule